// File: doc/BRIEF.md
# Two-Bit Serial Register Bus Target

This block is the target end of a narrow serial register-access bus that moves two bits on every clock. A requester raises a request strobe and drives a 2-bit input lane. The first beat carries the operation flag and the lowest address bit. The following beats carry the rest of a 17-bit address, lowest pair first. A write continues with its data pairs in the same order. A read ends its request after the address, and the target returns the data on a separate 2-bit output lane.

On the local side the block drives a simple register port: an address, write data, a one-cycle write strobe, a one-cycle read strobe, and a read-data input that is sampled in the read-strobe cycle. The data width is a build-time parameter, 32 or 8 bits. The request length follows from it: 9 address beats plus `DATA_W/2` data beats. An acknowledge marks the end of a write, and it stays up for the whole of a read-data phase. If the request falls before the frame is complete, the transfer is abandoned without any side effect.

Top module: `pairbus_target`

## Requirements
- R1: On the first beat of a frame (request rising while idle), `lane_in[0]` is the operation flag (1 = write, 0 = read) and `lane_in[1]` is address bit 0.
- R2: Beats 1 to 8 carry address bits in pairs, lowest pair first, with the higher-numbered bit on `lane_in[1]` (beat k carries A(2k) on bit 1 and A(2k-1) on bit 0). The assembled 17-bit address appears on `reg_addr` whenever `reg_we` or `reg_re` is high.
- R3: A write frame holds the request for exactly 9 + DATA_W/2 beats (25 beats for 32 bits, 13 beats for 8 bits). Data beat j carries D(2j+1) on `lane_in[1]` and D(2j) on `lane_in[0]`, and the full word appears on `reg_wdata` with `reg_we`.
- R4: `reg_we` is high for exactly one cycle: the cycle after the clock edge that captures the last data beat.
- R5: `ack` is high for exactly one cycle, in the cycle directly after `reg_we`.
- R6: A read frame holds the request for exactly 9 beats. `reg_re` is high for one cycle, the cycle after the last address beat, and `reg_rdata` is sampled in that cycle.
- R7: In the cycle after `reg_re`, `ack` rises and stays high for DATA_W/2 consecutive cycles. In cycle j of that phase, `lane_out` carries read bits 2j+1 (on bit 1) and 2j (on bit 0).
- R8: If the request falls during the address beats or the write-data beats, the frame is dropped. No `reg_we`, `reg_re` or `ack` follows, and the block accepts a new frame on the next request.
- R9: `lane_out` is 2'b00 in every cycle outside a read-data phase.
- R10: While `rst_n` is low, and directly after it rises, `ack`, `reg_we` and `reg_re` are low and `lane_out` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, high for the beats of a frame |
| lane_in | input | 2 | Incoming bit pair for each beat |
| ack | output | 1 | Write completion pulse, or read-data valid |
| lane_out | output | 2 | Outgoing read-data bit pair |
| reg_addr | output | 17 | Register address to the local port |
| reg_wdata | output | DATA_W | Write data to the local port |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | DATA_W | Read data from the local port, valid in the `reg_re` cycle |

## Verification
The assertions assume a well-behaved requester. It raises the request only while the target is idle. It lowers the request in the cycle right after the last beat of a complete frame. It keeps the request low until the write acknowledge or the read-data phase has ended, and it presents valid read data in the read-strobe cycle. The bench tasks follow this discipline by construction. Each frame is driven to its exact length and the request is then dropped, or it is dropped early on purpose to produce an abort. No new frame starts until the checks on the acknowledge and the data phase have run their course.

// File: rtl/pairbus_pkg.sv
package pairbus_pkg;
  localparam int ADDR_W    = 17;
  localparam int HDR_BEATS = (ADDR_W + 1) / 2;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WDATA, S_WREN, S_WACK, S_RDREQ, S_RDOUT
  } seq_state_e;

  function automatic int data_beats(int dw);
    return dw / 2;
  endfunction

  function automatic int frame_beats(int dw);
    return HDR_BEATS + data_beats(dw);
  endfunction

  function automatic int cnt_bits(int dw);
    return $clog2(frame_beats(dw));
  endfunction
endpackage

// File: rtl/pairbus_seq.sv
module pairbus_seq
  import pairbus_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = cnt_bits(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             op_write,
  output logic             cap_en,
  output logic [CNT_W-1:0] beat_idx,
  output logic             wr_issue,
  output logic             wr_ack,
  output logic             rd_issue,
  output logic             rd_phase
);
  localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_BEATS - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(frame_beats(DATA_W) - 1);
  localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(data_beats(DATA_W) - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             in_frame;

  assign in_frame = (state_q == S_ADDR) || (state_q == S_WDATA);
  assign cap_en   = req && (in_frame || state_q == S_IDLE);
  assign beat_idx = (state_q == S_IDLE) ? '0 : cnt_q;
  assign wr_issue = (state_q == S_WREN);
  assign wr_ack   = (state_q == S_WACK);
  assign rd_issue = (state_q == S_RDREQ);
  assign rd_phase = (state_q == S_RDOUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req) begin
          state_q <= S_ADDR;
          cnt_q   <= CNT_W'(1);
        end
        S_ADDR: begin
          if (!req) state_q <= S_IDLE;
          else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == HDR_LAST) state_q <= op_write ? S_WDATA : S_RDREQ;
          end
        end
        S_WDATA: begin
          if (!req) state_q <= S_IDLE;
          else if (cnt_q == FRAME_LAST) state_q <= S_WREN;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_WREN:  state_q <= S_WACK;
        S_WACK:  state_q <= S_IDLE;
        S_RDREQ: begin
          state_q <= S_RDOUT;
          cnt_q   <= '0;
        end
        S_RDOUT: begin
          if (cnt_q == RD_LAST) state_q <= S_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R8: a dropped request mid-frame lands in idle
  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !req) |=> (state_q == S_IDLE && !wr_issue && !rd_issue));

  // R4/R5: write strobe lasts one cycle and the acknowledge follows it
  assert_we_then_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_issue |=> (wr_ack && !wr_issue));
endmodule

// File: rtl/pairbus_deser.sv
module pairbus_deser
  import pairbus_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = cnt_bits(DATA_W),
  localparam int FRAME_BITS = 2 * frame_beats(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [CNT_W-1:0]  beat_idx,
  input  logic [1:0]        lane_in,
  output logic              op_write,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BEATS - 1);

  // Stream image: {data, address, op}; beat k fills bits 2k+1:2k
  logic [FRAME_BITS-1:0] img_q;

  always_ff @(posedge clk) begin
    if (!rst_n) img_q <= '0;
    else if (cap_en) img_q[{beat_idx, 1'b0} +: 2] <= lane_in;
  end

  assign op_write = img_q[0];
  assign addr     = img_q[ADDR_W:1];
  assign wdata    = img_q[FRAME_BITS-1 -: DATA_W];

  // R1: the flag comes from lane bit 0 of the first beat
  assert_op_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && beat_idx == '0) |=> (op_write == $past(lane_in[0])));

  // R2: data beats leave the captured address untouched
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && beat_idx > HDR_LAST) |=> $stable(addr));
endmodule

// File: rtl/pairbus_ser.sv
module pairbus_ser #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] rd_data,
  output logic [1:0]        lane_out
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else if (load) sh_q <= rd_data;
    else if (shift) sh_q <= {2'b00, sh_q[DATA_W-1:2]};
  end

  assign lane_out = shift ? sh_q[1:0] : 2'b00;
endmodule

// File: rtl/pairbus_target.sv
module pairbus_target
  import pairbus_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [1:0]        lane_in,
  output logic              ack,
  output logic [1:0]        lane_out,
  output logic [16:0]       reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int CNT_W = cnt_bits(DATA_W);
  localparam int DB    = data_beats(DATA_W);
  localparam int RUN_W = $clog2(DB + 1);

  logic             cap_en, op_write, wr_issue, wr_ack, rd_issue, rd_phase;
  logic [CNT_W-1:0] beat_idx;

  pairbus_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .op_write(op_write),
    .cap_en(cap_en), .beat_idx(beat_idx), .wr_issue(wr_issue),
    .wr_ack(wr_ack), .rd_issue(rd_issue), .rd_phase(rd_phase)
  );

  pairbus_deser #(.DATA_W(DATA_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .beat_idx(beat_idx),
    .lane_in(lane_in), .op_write(op_write), .addr(reg_addr), .wdata(reg_wdata)
  );

  pairbus_ser #(.DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(rd_issue), .shift(rd_phase),
    .rd_data(reg_rdata), .lane_out(lane_out)
  );

  assign ack    = wr_ack | rd_phase;
  assign reg_we = wr_issue;
  assign reg_re = rd_issue;

  // Length of the current read acknowledge run, for R7
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (rd_phase) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  // R9: the output lane is quiet whenever no acknowledge is up
  assert_lane_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (lane_out == 2'b00));

  // R7: a read acknowledge run lasts exactly DATA_W/2 cycles
  assert_rd_ack_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_phase) |-> (run_q == RUN_W'(DB)));

  // R6: the read strobe is one cycle and data starts right after it
  assert_re_to_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> (ack && !reg_re));

  // R4: strobes and acknowledge never overlap
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, reg_re, ack}));

  // R2: address is steady while the write strobe is up
  assert_addr_at_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $stable(reg_addr));
endmodule

// File: tb/test_pairbus_target.sv
module test_pairbus_target;
  localparam int DW = 32;
  localparam int DB = DW / 2;
  localparam int FB = 9 + DB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [1:0]    lane_in = 2'b00;
  logic          ack;
  logic [1:0]    lane_out;
  logic [16:0]   reg_addr;
  logic [DW-1:0] reg_wdata;
  logic          reg_we, reg_re;
  logic [DW-1:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  int we_count = 0;

  logic [DW-1:0] regs   [16];
  logic [DW-1:0] shadow [16];

  always #10 clk = ~clk;

  pairbus_target #(.DATA_W(DW)) i_pairbus_target (
    .clk(clk), .rst_n(rst_n), .req(req), .lane_in(lane_in), .ack(ack),
    .lane_out(lane_out), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  // Bench-side register file behind the local port
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) regs[k] <= '0;
    end else if (reg_we) begin
      regs[reg_addr[3:0]] <= reg_wdata;
      we_count <= we_count + 1;
    end
  end
  assign reg_rdata = regs[reg_addr[3:0]];

  function automatic logic [2*FB-1:0] frame_of(bit wr, logic [16:0] a, logic [DW-1:0] d);
    return {d, a, wr};
  endfunction

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle_quiet(string rq, int n);
    for (int k = 0; k < n; k++) begin
      chk(!reg_we && !reg_re && !ack && lane_out == 2'b00, rq,
          {reg_we, reg_re, ack, lane_out}, 0);
      @(negedge clk);
    end
  endtask

  // send = number of beats driven; FB means a complete write
  task automatic do_write(logic [16:0] a, logic [DW-1:0] d, int send);
    logic [2*FB-1:0] fr = frame_of(1'b1, a, d);
    int base = we_count;
    for (int i = 0; i < send; i++) begin
      @(negedge clk);
      if (i > 0) chk(!reg_we && !ack, "R4", {reg_we, ack}, 0);
      req = 1'b1;
      lane_in = fr[2*i +: 2];
    end
    @(negedge clk);
    req = 1'b0;
    lane_in = 2'b00;
    if (send == FB) begin
      chk(reg_we == 1'b1, "R4", reg_we, 1);
      chk(reg_addr == a, "R2", reg_addr, a);
      chk(reg_wdata == d, "R3", reg_wdata, d);
      shadow[a[3:0]] = d;
      @(negedge clk);
      chk(ack && !reg_we, "R5", {ack, reg_we}, 2'b10);
      chk(lane_out == 2'b00, "R9", lane_out, 0);
      @(negedge clk);
      chk(!ack, "R5", ack, 0);
    end else begin
      idle_quiet("R8", 3);
      chk(we_count == base, "R8", we_count, base);
    end
  endtask

  task automatic do_read(logic [16:0] a, int send);
    logic [2*FB-1:0] fr = frame_of(1'b0, a, '0);
    logic [DW-1:0] exp;
    for (int i = 0; i < send; i++) begin
      @(negedge clk);
      req = 1'b1;
      lane_in = fr[2*i +: 2];
    end
    @(negedge clk);
    req = 1'b0;
    lane_in = 2'b00;
    if (send == 9) begin
      chk(reg_re && !ack, "R6", {reg_re, ack}, 2'b10);
      chk(reg_addr == a, "R2", reg_addr, a);
      exp = shadow[a[3:0]];
      for (int j = 0; j < DB; j++) begin
        @(negedge clk);
        chk(ack && !reg_re, "R7", {ack, reg_re}, 2'b10);
        chk(lane_out == exp[2*j +: 2], "R7", lane_out, exp[2*j +: 2]);
      end
      @(negedge clk);
      chk(!ack && lane_out == 2'b00, "R9", {ack, lane_out}, 0);
    end else begin
      idle_quiet("R8", 3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) shadow[k] = '0;
    repeat (3) @(negedge clk);
    chk(!ack && !reg_we && !reg_re && lane_out == 2'b00, "R10",
        {ack, reg_we, reg_re, lane_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_quiet("R10", 2);

    // Directed corners: extreme address bits (R1, R2), all-ones data (R3)
    do_write(17'h1FFFF, 32'hFFFF_FFFF, FB);
    do_read(17'h1FFFF, 9);
    do_write(17'h10001, 32'h8000_0001, FB);
    do_read(17'h10001, 9);
    do_write(17'h00002, 32'hA5C3_1E69, FB);
    do_read(17'h00002, 9);
    // Aborts in the address phase, at the header edge and on the last data beat (R8)
    do_write(17'h00005, 32'h1234_5678, 1);
    do_write(17'h00005, 32'h1234_5678, 8);
    do_write(17'h00005, 32'h1234_5678, 9);
    do_write(17'h00005, 32'h1234_5678, FB - 1);
    do_read(17'h00005, 5);
    do_read(17'h00005, 9);   // the aborted writes left the old value in place

    begin
      void'($urandom(32'd4242));
      for (int t = 0; t < 60; t++) begin
        logic [16:0] a  = 17'($urandom);
        logic [DW-1:0] d = DW'($urandom);
        bit wr = $urandom_range(0, 1) == 1;
        bit cut = $urandom_range(0, 4) == 0;
        if (wr) do_write(a, d, cut ? int'($urandom_range(1, FB - 1)) : FB);
        else    do_read(a, cut ? int'($urandom_range(1, 8)) : 9);
        if ($urandom_range(0, 2) == 0) idle_quiet("R9", 1);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule